// File: doc/BRIEF.md
# Triple-Buffer Rotation Controller

This block sequences a coarse-grain pipeline of three stages that share a pool of three tile buffers. Stage 0 fills a buffer with operands and the previous partial result, stage 1 accumulates into that buffer in place, and stage 2 drains the buffer back to memory. Because the result tile is modified by both of the first two stages, every iteration in flight needs a buffer of its own. The controller hands each stage the index of the buffer it must use and starts the stages with one-cycle pulses. It advances to the next pipeline step only after every stage started in the current step has reported completion.

Work is organised as a number of rows, each holding a run-time count of tiles. Every row begins with an empty pipeline and ends with a drained one. During the first two steps of a row the later stages have no work, and during the last two steps the earlier stages have none. Idle stages are neither started nor waited on. The buffer rotation restarts at index 0 on every row. After the final drain step of the last row the controller emits a single done pulse and returns to idle. The stage count is a parameter with a default of three.

Top module: `tribuf_rotator`

## Requirements
- R1: While reset is held, and afterwards until a job is started, `stg_start`, `stg_en`, `done` and `busy` are all 0.
- R2: For a row of R tiles the controller runs R+2 steps, numbered t = 0 to R+1. At step t, stage s (bit s of `stg_en`) is enabled exactly when s <= t < R+s.
- R3: At step t, the 2-bit field `stg_buf[2s+1:2s]` of an enabled stage s equals (t - s) mod 3. Because t restarts at 0 on every row, the rotation restarts as well, and load therefore uses buffer 0 at the first step of each row.
- R4: A step ends only after every enabled stage has pulsed its `stg_done` bit since that step was launched. Done pulses can arrive in any order and with any latency of one cycle or more. Done pulses on disabled stages, and done pulses while idle, have no effect.
- R5: Each step begins with a single cycle in which `stg_start` equals that step's enable mask. In every other cycle `stg_start` is 0. The launch cycle of a step follows one cycle after the last required done pulse of the previous step. The launch cycle of the first step follows one cycle after `start`.
- R6: After the last required done pulse of the final step of the last row, `done` is 1 for exactly one cycle, beginning the next cycle, and `busy` is 0 from that same cycle.
- R7: With R = 1, every step enables exactly one stage, in the order load, compute, write-back, and all three use buffer 0.
- R8: A `start` with `row_len` = 0 or `num_rows` = 0 produces the `done` pulse in the next cycle without starting any stage.
- R9: A `start` while `busy` is 1 is ignored. The running job keeps its latched row length and row count.
- R10: `step_idx` shows the current step t and `row_idx` shows the current row, counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; sampled only when idle |
| row_len | input | LEN_W (6) | Tiles per row, latched at start |
| num_rows | input | ROWS_W (4) | Number of rows, latched at start |
| stg_done | input | NSTAGE (3) | Per-stage completion pulses |
| stg_start | output | NSTAGE (3) | Per-stage one-cycle start pulses |
| stg_en | output | NSTAGE (3) | Stages holding a valid iteration in the current step |
| stg_buf | output | NSTAGE*BW (6) | Buffer index per stage, stage s at bits [BW*s +: BW] |
| step_idx | output | STEP_W (8) | Step within the current row |
| row_idx | output | ROWS_W (4) | Current row |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at job completion |

## Verification
The bench targets the edges of each row. It checks that a controller which starts write-back during fill, or load during drain, shows a wrong enable mask at steps 0, 1, R and R+1, and that one which forgets to reset the rotation shows a nonzero load buffer on the second row. Stage latencies are staggered so that a step which advances on the first done pulse instead of the last produces an early launch, and stray done pulses are placed on idle stages. The single-tile row, the empty jobs and a start pulse issued mid-job expose designs that overlap the stages, that start work for nothing, or that restart over a running job.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LAUNCH = 2'd1,
      ST_WAIT   = 2'd2
   } rot_state_e;
endpackage

// File: rtl/tribuf_stepper.sv
module tribuf_stepper #(
   parameter int LEN_W  = 6,
   parameter int ROWS_W = 4,
   parameter int NSTAGE = 3,
   parameter int BW     = 2,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic              active,
   input  logic [LEN_W-1:0]  len,
   input  logic [ROWS_W-1:0] rows,
   output logic [STEP_W-1:0] step,
   output logic [ROWS_W-1:0] row,
   output logic [BW-1:0]     rot,
   output logic              last_step,
   output logic              last_row
);
   localparam logic [STEP_W-1:0] TAIL    = STEP_W'(NSTAGE - 2);
   localparam logic [BW-1:0]     ROT_TOP = BW'(NSTAGE - 1);

   logic [STEP_W-1:0] step_q;
   logic [ROWS_W-1:0] row_q;
   logic [BW-1:0]     rot_q;
   logic [STEP_W-1:0] last_val;

   assign last_val  = {{(STEP_W-LEN_W){1'b0}}, len} + TAIL;
   assign last_step = (step_q == last_val);
   assign last_row  = (row_q == rows - ROWS_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         step_q <= '0;
         row_q  <= '0;
         rot_q  <= '0;
      end else if (adv) begin
         if (last_step) begin
            step_q <= '0;
            rot_q  <= '0;
            row_q  <= row_q + ROWS_W'(1);
         end else begin
            step_q <= step_q + STEP_W'(1);
            rot_q  <= (rot_q == ROT_TOP) ? '0 : rot_q + BW'(1);
         end
      end
   end

   assign step = step_q;
   assign row  = row_q;
   assign rot  = rot_q;

   p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (step_q <= last_val));
   p_rot_row_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == '0) |-> (rot_q == '0));
   p_row_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (row_q < rows));
endmodule

// File: rtl/tribuf_stage_gate.sv
module tribuf_stage_gate #(
   parameter int LEN_W  = 6,
   parameter int NSTAGE = 3,
   parameter int BW     = 2,
   parameter int STEP_W = 8,
   parameter int SIDX   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              done_in,
   input  logic [STEP_W-1:0] step,
   input  logic [LEN_W-1:0]  len,
   input  logic [BW-1:0]     rot,
   output logic              en,
   output logic [BW-1:0]     bsel,
   output logic              fin
);
   localparam logic [STEP_W-1:0] SI   = STEP_W'(SIDX);
   localparam logic [BW-1:0]     SB   = BW'(SIDX);
   localparam logic [BW-1:0]     WRAP = BW'(NSTAGE - SIDX);

   logic upper_ok;
   logic fin_q;

   assign upper_ok = (step < ({{(STEP_W-LEN_W){1'b0}}, len} + SI));

   generate
      if (SIDX == 0) begin : g_first
         assign en   = upper_ok;
         assign bsel = rot;
      end else begin : g_later
         assign en   = (step >= SI) && upper_ok;
         assign bsel = (rot >= SB) ? (rot - SB) : (rot + WRAP);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) fin_q <= 1'b0;
      else if (done_in)  fin_q <= 1'b1;
   end

   assign fin = fin_q | done_in | ~en;

   p_fin_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !fin_q);
endmodule

// File: rtl/tribuf_rotator.sv
module tribuf_rotator
   import tribuf_pkg::*;
#(
   parameter int LEN_W  = 6,
   parameter int ROWS_W = 4,
   parameter int NSTAGE = 3,
   parameter int BW     = (NSTAGE > 1) ? $clog2(NSTAGE) : 1,
   parameter int STEP_W = LEN_W + $clog2(NSTAGE)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [LEN_W-1:0]     row_len,
   input  logic [ROWS_W-1:0]    num_rows,
   input  logic [NSTAGE-1:0]    stg_done,
   output logic [NSTAGE-1:0]    stg_start,
   output logic [NSTAGE-1:0]    stg_en,
   output logic [NSTAGE*BW-1:0] stg_buf,
   output logic [STEP_W-1:0]    step_idx,
   output logic [ROWS_W-1:0]    row_idx,
   output logic                 busy,
   output logic                 done
);
   generate
      if (NSTAGE < 2)      begin : g_bad_stages $error("NSTAGE must be at least 2"); end
      if (LEN_W < 1)       begin : g_bad_len    $error("LEN_W must be at least 1"); end
      if (ROWS_W < 1)      begin : g_bad_rows   $error("ROWS_W must be at least 1"); end
      if (STEP_W <= LEN_W) begin : g_bad_step   $error("STEP_W too narrow for fill and drain"); end
   endgenerate

   rot_state_e        state_q;
   logic [LEN_W-1:0]  len_q;
   logic [ROWS_W-1:0] rows_q;
   logic              done_q;

   logic              accept, empty_job, launch, waiting, all_fin, adv, finish;
   logic              last_step, last_row;
   logic [BW-1:0]     rot;
   logic [NSTAGE-1:0] en_v, fin_v;
   logic [BW-1:0]     bsel_a [NSTAGE];

   assign accept    = (state_q == ST_IDLE) && start;
   assign empty_job = (row_len == '0) || (num_rows == '0);
   assign launch    = (state_q == ST_LAUNCH);
   assign waiting   = (state_q == ST_WAIT);
   assign all_fin   = &fin_v;
   assign finish    = waiting && all_fin && last_step && last_row;
   assign adv       = waiting && all_fin && !finish;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         rows_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               if (empty_job) done_q <= 1'b1;
               else begin
                  len_q   <= row_len;
                  rows_q  <= num_rows;
                  state_q <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: state_q <= ST_WAIT;
            ST_WAIT: if (all_fin) begin
               if (finish) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else state_q <= ST_LAUNCH;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   tribuf_stepper #(
      .LEN_W(LEN_W), .ROWS_W(ROWS_W), .NSTAGE(NSTAGE), .BW(BW), .STEP_W(STEP_W)
   ) u_stepper (
      .clk(clk), .rst_n(rst_n), .clr(accept), .adv(adv), .active(busy),
      .len(len_q), .rows(rows_q), .step(step_idx), .row(row_idx), .rot(rot),
      .last_step(last_step), .last_row(last_row)
   );

   for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
      tribuf_stage_gate #(
         .LEN_W(LEN_W), .NSTAGE(NSTAGE), .BW(BW), .STEP_W(STEP_W), .SIDX(s)
      ) u_gate (
         .clk(clk), .rst_n(rst_n), .clr(launch),
         .done_in(stg_done[s] & waiting & en_v[s]),
         .step(step_idx), .len(len_q), .rot(rot),
         .en(en_v[s]), .bsel(bsel_a[s]), .fin(fin_v[s])
      );
      assign stg_buf[s*BW +: BW] = bsel_a[s];
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign stg_en    = busy ? en_v : '0;
   assign stg_start = launch ? en_v : '0;

   p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|stg_start) |=> (stg_start == '0));
   p_launch_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (stg_start != '0));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_hold_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !all_fin) |=> ($stable(step_idx) && $stable(row_idx) && stg_start == '0));
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (stg_start == '0 && stg_en == '0));
endmodule

// File: tb/tribuf_rotator_tb.sv
module tribuf_rotator_tb;
   localparam int LEN_W = 6, ROWS_W = 4, NS = 3, BW = 2, STEP_W = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [LEN_W-1:0]     row_len = '0;
   logic [ROWS_W-1:0]    num_rows = '0;
   logic [NS-1:0]        stg_done = '0;
   logic [NS-1:0]        stg_start, stg_en;
   logic [NS*BW-1:0]     stg_buf;
   logic [STEP_W-1:0]    step_idx;
   logic [ROWS_W-1:0]    row_idx;
   logic                 busy, done;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   tribuf_rotator #(.LEN_W(LEN_W), .ROWS_W(ROWS_W), .NSTAGE(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .row_len(row_len), .num_rows(num_rows),
      .stg_done(stg_done), .stg_start(stg_start), .stg_en(stg_en), .stg_buf(stg_buf),
      .step_idx(step_idx), .row_idx(row_idx), .busy(busy), .done(done)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // R1: reset and idle state
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 start", int'(stg_start), 0);
      check("R1 en", int'(stg_en), 0);
      check("R1 done", int'(done), 0);
      check("R1 busy", int'(busy), 0);
      rst_n = 1'b1;
      stg_done = 3'b111;   // stray done while idle
      @(negedge clk);
      stg_done = '0;
      @(negedge clk);
      check("R1 idle busy", int'(busy), 0);
      check("R4 idle stray done", int'(stg_start), 0);
   endtask

   // Runs a job and checks every step (R2 R3 R4 R5 R6 R7 R9 R10)
   task automatic run_job(input int R, input int rows, input int seed, input bit poke);
      row_len = LEN_W'(R);
      num_rows = ROWS_W'(rows);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int row = 0; row < rows; row++) begin
         for (int t = 0; t < R + 2; t++) begin
            int w = 0;
            int mask = 0;
            int maxl = 0;
            int lat [NS];
            while (stg_start == '0 && w < 60) begin
               @(negedge clk);
               w++;
            end
            if (w >= 60) begin
               check("R5 launch timeout", 0, 1);
               return;
            end
            for (int s = 0; s < NS; s++) begin
               if (t >= s && t < R + s) mask |= (1 << s);
               lat[s] = 1 + ((t * 7 + s * 3 + row + seed) % 4);
               if (((mask >> s) & 1) != 0 && lat[s] > maxl) maxl = lat[s];
            end
            check("R5 start mask", int'(stg_start), mask);
            check("R2 enable mask", int'(stg_en), mask);
            check("R10 step_idx", int'(step_idx), t);
            check("R10 row_idx", int'(row_idx), row);
            check("R6 no early done", int'(done), 0);
            for (int s = 0; s < NS; s++) begin
               if (((mask >> s) & 1) != 0)
                  check("R3 buffer index", int'(stg_buf[s*BW +: BW]), ((t - s) % 3 + 3) % 3);
            end
            if (R == 1) begin
               check("R7 one stage", $countones(stg_start), 1);
               check("R7 buffer zero", int'(stg_buf[t*BW +: BW]), 0);
            end
            for (int c = 1; c <= maxl; c++) begin
               int dm = 0;
               @(negedge clk);
               check("R4 no early advance", int'(stg_start), 0);
               for (int s = 0; s < NS; s++)
                  if (((mask >> s) & 1) != 0 && lat[s] == c) dm |= (1 << s);
               if (c == 1) dm |= (~mask) & 7;   // stray done on disabled stages
               stg_done = NS'(dm);
               if (poke && row == 0 && t == 1 && c == 1) begin
                  start = 1'b1;
                  row_len = LEN_W'(R + 5);
                  num_rows = ROWS_W'(rows + 3);
               end
            end
            @(negedge clk);
            stg_done = '0;
            start = 1'b0;
            row_len = LEN_W'(R);
            num_rows = ROWS_W'(rows);
         end
      end
      check("R6 done pulse", int'(done), 1);
      check("R6 busy low", int'(busy), 0);
      @(negedge clk);
      check("R6 done single", int'(done), 0);
      check("R9 no restart", int'(stg_start), 0);
      check("R9 still idle", int'(busy), 0);
   endtask

   // R8: empty jobs
   task automatic t_empty(input int R, input int rows);
      row_len = LEN_W'(R);
      num_rows = ROWS_W'(rows);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8 done immediate", int'(done), 1);
      check("R8 no start", int'(stg_start), 0);
      check("R8 not busy", int'(busy), 0);
      @(negedge clk);
      check("R8 done single", int'(done), 0);
      check("R8 still quiet", int'(stg_start), 0);
   endtask

   initial begin
      t_reset();
      run_job(4, 2, 0, 1'b0);
      run_job(1, 3, 1, 1'b0);
      run_job(7, 1, 2, 1'b0);
      t_empty(0, 2);
      t_empty(3, 0);
      run_job(2, 2, 3, 1'b1);   // R9 start pulsed mid-job
      run_job(3, 1, 1, 1'b1);   // R9
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end
endmodule